// File: doc/BRIEF.md
# UART Hardware Flow Control

This block sits between the receive and transmit FIFOs of a UART and the serial line's handshake pins. It decides the level of the request-to-send output and whether the transmitter may begin its next character. The FIFOs and the serializers are outside it. The transmitter presents a start request when it has a character ready and its shifter is idle. The block answers with a grant. A character that is already being shifted out is never interrupted, because only the start of a character is gated.

In manual mode, software alone drives the request-to-send output, through its modem control bit. When flow control is enabled, the output is also withdrawn while the receive FIFO holds at least a selectable number of entries. It is offered again as soon as the fill level falls below that number. The clear-to-send input passes through a two-flop synchronizer, and the synchronized value gates the transmit start. Two such blocks with request-to-send wired to clear-to-send never send a character into a receiver that has no room. Loop mode and reset both force request-to-send to its inactive level.

Top module: `uart_autoflow`

## Requirements
- R1: While reset is asserted and right after it, rts_n_o is 1. The synchronized clear-to-send reads as inactive until the input has passed two rising clock edges.
- R2: With afc_en_i = 0 and loop_i = 0, rts_n_o takes the value of the inverted mcr_rts_i at the next rising edge (mcr_rts_i = 1 gives rts_n_o = 0).
- R3: Whenever loop_i = 1, rts_n_o is 1 after the next rising edge, whatever the other inputs are.
- R4: With afc_en_i = 1, rts_n_o is 1 after the next rising edge whenever rx_level_i is at or above the trigger level. The trigger level for trig_sel_i = 0, 1, 2 and 3 is 1, 4, 8 and 14 entries of the default 16-deep FIFO.
- R5: With afc_en_i = 1, mcr_rts_i = 1 and loop_i = 0, rts_n_o returns to 0 at the next rising edge once rx_level_i drops below the trigger level.
- R6: With afc_en_i = 0, rx_level_i and trig_sel_i have no effect on rts_n_o.
- R7: A change on cts_n_i reaches the transmit gate on the second rising edge after it, and not on the first.
- R8: With afc_en_i = 1, tx_go_o equals tx_req_i while the synchronized cts_n_i is 0, and is 0 while it is 1. tx_go_o responds to tx_req_i in the same cycle.
- R9: With afc_en_i = 0, tx_go_o equals tx_req_i whatever cts_n_i is.
- R10: With rts_n_o fed back into cts_n_i and flow control on, a fill level at the trigger level takes tx_go_o to 0 within three rising edges, and a level below it restores tx_go_o within three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send from the line, active low, asynchronous |
| rts_n_o | output | 1 | Request-to-send to the line, active low, registered |
| rx_level_i | input | 5 | Receive FIFO fill level, 0 to 16 |
| trig_sel_i | input | 2 | Trigger select: 0→1, 1→4, 2→8, 3→14 entries |
| tx_req_i | input | 1 | Transmitter ready to start a character |
| tx_go_o | output | 1 | Start grant to the transmitter |
| mcr_rts_i | input | 1 | Modem control request-to-send bit |
| afc_en_i | input | 1 | Hardware flow control enable |
| loop_i | input | 1 | Loop mode flag |

## Verification
The request-to-send path is swept over every trigger select, every fill level from empty to full, and all eight combinations of enable, control bit and loop. The levels right at and right below each trigger show the exact threshold comparison. The combinations with flow control off show that the fill level is ignored there. The clear-to-send path is tried with steps in both directions, sampled after one edge and after two, which separates a two-flop delay from a shorter or longer one. A loopback pattern, with the block's output fed back as its own input, ties the receive threshold to the transmit gate from end to end.

// File: rtl/uart_afc_pkg.sv
package uart_afc_pkg;

    typedef enum logic [1:0] {
        TRIG_SINGLE  = 2'd0,
        TRIG_QUARTER = 2'd1,
        TRIG_HALF    = 2'd2,
        TRIG_NEARTOP = 2'd3
    } trig_sel_e;

    // Entry count at which the receive side withdraws its request.
    function automatic int unsigned trig_entries(input logic [1:0] sel,
                                                 input int unsigned depth);
        int unsigned n;
        case (trig_sel_e'(sel))
            TRIG_SINGLE:  n = 1;
            TRIG_QUARTER: n = depth / 4;
            TRIG_HALF:    n = depth / 2;
            default:      n = depth - 2;
        endcase
        return n;
    endfunction

    typedef struct packed {
        logic rts_n;
        logic above;
    } rts_state_t;

endpackage

// File: rtl/afc_cts_sync.sv
module afc_cts_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    // Reset to the inactive (high) level so nothing is granted early.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    a_r1_sync_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> sync_o);
endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
    import uart_afc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    input  logic [1:0]       sel_i,
    input  logic             mcr_rts_i,
    input  logic             afc_en_i,
    input  logic             loop_i,
    output logic             rts_n_o
);
    rts_state_t st_d, st_q;
    logic [LVL_W-1:0] thr;

    always_comb begin
        thr         = LVL_W'(trig_entries(sel_i, DEPTH));
        st_d.above  = (level_i >= thr);
        st_d.rts_n  = 1'b1;
        if (mcr_rts_i && !loop_i && !(afc_en_i && st_d.above))
            st_d.rts_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rts_n: 1'b1, above: 1'b0};
        else        st_q <= st_d;
    end

    assign rts_n_o = st_q.rts_n;

    a_r3_loop_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        loop_i |=> rts_n_o);
    a_r2_mcr_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_rts_i |=> rts_n_o);
    a_r4_full_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en_i && level_i >= thr) |=> rts_n_o);
    a_r6_manual_ignores_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!afc_en_i && mcr_rts_i && !loop_i) |=> !rts_n_o);
    a_r5_room_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en_i && mcr_rts_i && !loop_i && level_i < thr) |=> !rts_n_o);
endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_sync_i,
    input  logic afc_en_i,
    input  logic tx_req_i,
    output logic tx_go_o
);
    logic allow;

    always_comb begin
        allow   = !afc_en_i || !cts_n_sync_i;
        tx_go_o = tx_req_i && allow;
    end

    a_r8_hold_when_cts_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en_i && cts_n_sync_i) |-> !tx_go_o);
    a_r9_pass_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !afc_en_i |-> (tx_go_o == tx_req_i));
    a_r8_no_grant_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req_i |-> !tx_go_o);
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
    import uart_afc_pkg::*;
#(
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_n_i,
    output logic             rts_n_o,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             tx_req_i,
    output logic             tx_go_o,
    input  logic             mcr_rts_i,
    input  logic             afc_en_i,
    input  logic             loop_i
);
    logic cts_n_sync;

    afc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cts_n_i),
        .sync_o  (cts_n_sync)
    );

    afc_rts_ctrl #(.DEPTH(DEPTH)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (rx_level_i),
        .sel_i     (trig_sel_i),
        .mcr_rts_i (mcr_rts_i),
        .afc_en_i  (afc_en_i),
        .loop_i    (loop_i),
        .rts_n_o   (rts_n_o)
    );

    afc_tx_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_n_sync_i (cts_n_sync),
        .afc_en_i     (afc_en_i),
        .tx_req_i     (tx_req_i),
        .tx_go_o      (tx_go_o)
    );
endmodule

// File: tb/uart_autoflow_test.sv
module uart_autoflow_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_drv = 1'b1;
    logic       lb_mode = 1'b0;
    logic       cts_n;
    logic       rts_n;
    logic [4:0] level = '0;
    logic [1:0] sel = '0;
    logic       req = 1'b0;
    logic       go;
    logic       mcr = 1'b0;
    logic       afc = 1'b0;
    logic       loopm = 1'b0;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;
    assign cts_n = lb_mode ? rts_n : cts_drv;

    uart_autoflow uut (
        .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n), .rts_n_o(rts_n),
        .rx_level_i(level), .trig_sel_i(sel), .tx_req_i(req), .tx_go_o(go),
        .mcr_rts_i(mcr), .afc_en_i(afc), .loop_i(loopm)
    );

    function automatic int thr_of(input int s);
        case (s)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string req_tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req_tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        afc = 1'b1; mcr = 1'b1; req = 1'b1; cts_drv = 1'b0;
        edges(3);
        chk("R1 rts in reset", rts_n, 1'b1);
        chk("R1 go in reset", go, 1'b0);
        rst_n = 1'b1;
        edges(1);
        chk("R1 go one edge after reset", go, 1'b0);
        edges(1);
        chk("R7 go two edges after reset", go, 1'b1);

        // R2 R3 R4 R5 R6: full sweep of the request-to-send path
        for (int s = 0; s < 4; s++)
            for (int l = 0; l <= 16; l++)
                for (int m = 0; m < 8; m++) begin
                    logic e;
                    sel = 2'(s); level = 5'(l);
                    afc = m[0]; mcr = m[1]; loopm = m[2];
                    edges(1);
                    e = !(mcr && !loopm && !(afc && l >= thr_of(s)));
                    if (loopm)          chk("R3 loop", rts_n, e);
                    else if (!afc)      chk("R2/R6 manual", rts_n, e);
                    else if (l >= thr_of(s)) chk("R4 at trigger", rts_n, e);
                    else                chk("R5 below trigger", rts_n, e);
                end

        // R7 R8: synchronizer depth and gating
        afc = 1'b1; loopm = 1'b0; req = 1'b1; cts_drv = 1'b0;
        edges(3);
        chk("R8 granted with cts", go, 1'b1);
        req = 1'b0; #1;
        chk("R8 no req no go", go, 1'b0);
        req = 1'b1; #1;
        chk("R8 same-cycle req", go, 1'b1);
        cts_drv = 1'b1;
        edges(1);
        chk("R7 one edge after drop", go, 1'b1);
        edges(1);
        chk("R7 two edges after drop", go, 1'b0);
        chk("R8 held without cts", go, 1'b0);
        cts_drv = 1'b0;
        edges(1);
        chk("R7 one edge after rise", go, 1'b0);
        edges(1);
        chk("R7 two edges after rise", go, 1'b1);

        // R9: disabled ignores cts
        cts_drv = 1'b1; afc = 1'b0;
        edges(3);
        chk("R9 pass with cts idle", go, 1'b1);
        req = 1'b0; #1;
        chk("R9 follows req", go, 1'b0);
        req = 1'b1;

        // R10: loopback, trigger 4
        afc = 1'b1; mcr = 1'b1; sel = 2'd1; level = 5'd3; lb_mode = 1'b1;
        edges(4);
        chk("R10 room allows start", go, 1'b1);
        level = 5'd4;
        edges(3);
        chk("R10 full blocks start", go, 1'b0);
        chk("R10 rts withdrawn", rts_n, 1'b1);
        level = 5'd2;
        edges(3);
        chk("R10 drained restarts", go, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule